// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block keeps the floating-point state that software can see: five sticky exception flags and a three-bit dynamic rounding mode. One pair of storage fields is reached through three CSR views. The flags view carries only the exception bits. The rounding view carries only the mode. The packed view carries both at once. Every access is a read-modify-write under a bit mask, and it returns the value the view held before the access.

The arithmetic datapath reports new exceptions on a separate input, and those bits are ORed into the sticky flags. The block also takes the current two-bit FP-state field of the machine status register. It refuses any access while that field reads Off, unless the access comes from the debugger. Whenever it accepts a write, it drives an update that marks the field Dirty. The current rounding mode and flags are available as outputs for the datapath.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset, the flags and the rounding mode are zero, so every view reads 0.
- R2: The flags view (`csr_sel` = 0) reads the flags in bits [4:0] with zeros above them. A write to it changes only the flags and keeps only bits [4:0] of the merged value.
- R3: The rounding view (`csr_sel` = 1) reads the mode in bits [2:0] with zeros above them. A write to it changes only the mode and keeps only bits [2:0]. Outside an accepted write, the mode holds its value.
- R4: The packed view (`csr_sel` = 2) reads the mode in bits [7:5] and the flags in bits [4:0].
- R5: An accepted access returns the view's old value on `csr_rdata` in the same cycle. The new value is (old AND NOT mask) OR (wdata AND mask), and it takes effect at the next clock edge.
- R6: In every view, the bits above the packed field read as zero and ignore writes.
- R7: An access made while `fs_in` = 2'b00 and `csr_dbg` = 0 is refused. A refused access raises `csr_err`, reads 0, leaves the state unchanged and raises no FP-state update.
- R8: An access with `csr_dbg` = 1 is accepted even while `fs_in` = 2'b00.
- R9: An accepted access with a nonzero mask raises `fs_upd_en` in the same cycle, with `fs_upd_val` = 2'b11. Otherwise `fs_upd_val` equals `fs_in`.
- R10: When `acc_valid` is high, `acc_flags` is ORed into the sticky flags at the next edge.
- R11: A write through a view that holds the flags (0 or 2) takes priority over accumulation in the same cycle. A write through the rounding view lets accumulation proceed.
- R12: The selector code 3 names no view. Any access to it is refused in the same way as in R7.
- R13: An accepted access with a zero mask changes no state and raises no FP-state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access in this cycle |
| csr_sel | input | 2 | View select: 0 flags, 1 rounding, 2 packed, 3 none |
| csr_dbg | input | 1 | Access comes from the debugger |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Bit mask for the write; zero means read only |
| csr_rdata | output | XLEN | Old value of the selected view |
| csr_err | output | 1 | Access refused |
| fs_in | input | 2 | Current FP-state field of the status register |
| fs_upd_en | output | 1 | Write the FP-state field |
| fs_upd_val | output | 2 | Next FP-state value |
| acc_valid | input | 1 | Datapath reports exceptions |
| acc_flags | input | 5 | Exception bits to accumulate |
| rm_o | output | 3 | Current rounding mode |
| flags_o | output | 5 | Current sticky flags |

## Verification
The hardest case to reach is a CSR write that lands in the same cycle as a datapath exception report. The outcome depends on which view is written: a flag-bearing view discards the report, and the rounding view lets it through. The driver therefore places a report on the same cycle as a flags-view write, and again on a rounding-view write. It then reads the packed view to expose both fields. Refusal is also covered under both debugger settings, to show that the state and the FP-state field are unchanged.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int FLG_W  = 5;
    localparam int RM_W   = 3;
    localparam int PACK_W = FLG_W + RM_W;

    localparam logic [1:0] FS_OFF   = 2'b00;
    localparam logic [1:0] FS_DIRTY = 2'b11;

    typedef enum logic [1:0] {
        VIEW_FLG = 2'd0,
        VIEW_RM  = 2'd1,
        VIEW_ALL = 2'd2,
        VIEW_BAD = 2'd3
    } view_e;

    // packed layout is behaviour: mode above flags
    typedef struct packed {
        logic [RM_W-1:0]  rm;
        logic [FLG_W-1:0] flg;
    } fpstate_t;

    typedef struct packed {
        logic     flg_we;
        logic     rm_we;
        fpstate_t val;
    } fpwr_t;

    function automatic logic view_has_flg(view_e v);
        return (v == VIEW_FLG) || (v == VIEW_ALL);
    endfunction

    function automatic logic view_has_rm(view_e v);
        return (v == VIEW_RM) || (v == VIEW_ALL);
    endfunction

    function automatic logic [PACK_W-1:0] pack_view(view_e v, fpstate_t s);
        logic [PACK_W-1:0] r;
        case (v)
            VIEW_FLG: r = {{RM_W{1'b0}}, s.flg};
            VIEW_RM:  r = {{FLG_W{1'b0}}, s.rm};
            VIEW_ALL: r = s;
            default:  r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fpcsr_gate.sv
module fpcsr_gate
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            req,
    input  view_e           sel,
    input  logic            dbg,
    input  logic [1:0]      fs_in,
    input  logic [XLEN-1:0] wmask,
    output logic            refused,
    output logic            granted,
    output logic            wr_go,
    output logic            fs_upd_en,
    output logic [1:0]      fs_upd_val
);
    logic fp_off;
    logic sel_bad;

    always_comb begin
        fp_off     = (fs_in == FS_OFF) && !dbg;
        sel_bad    = (sel == VIEW_BAD);
        refused    = req && (fp_off || sel_bad);
        granted    = req && !refused;
        wr_go      = granted && (wmask != '0);
        fs_upd_en  = wr_go;
        fs_upd_val = wr_go ? FS_DIRTY : fs_in;
    end
endmodule

// File: rtl/fpcsr_view.sv
module fpcsr_view
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  view_e           sel,
    input  fpstate_t        cur,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic            wr_go,
    output logic [XLEN-1:0] rdata,
    output fpwr_t           wr
);
    localparam int HI_W = XLEN - PACK_W;

    logic [XLEN-1:0] merged;

    always_comb begin
        rdata  = {{HI_W{1'b0}}, pack_view(sel, cur)};
        merged = (rdata & ~wmask) | (wdata & wmask);
        wr.val = cur;
        case (sel)
            VIEW_FLG: wr.val.flg = merged[FLG_W-1:0];
            VIEW_RM:  wr.val.rm  = merged[RM_W-1:0];
            VIEW_ALL: wr.val     = merged[PACK_W-1:0];
            default:  wr.val     = cur;
        endcase
        wr.flg_we = wr_go && view_has_flg(sel);
        wr.rm_we  = wr_go && view_has_rm(sel);
    end
endmodule

// File: rtl/fpcsr_regs.sv
module fpcsr_regs
    import fpcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fpwr_t            wr,
    input  logic             acc_valid,
    input  logic [FLG_W-1:0] acc_flags,
    output fpstate_t         cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (wr.flg_we)
                cur.flg <= wr.val.flg;
            else if (acc_valid)
                cur.flg <= cur.flg | acc_flags;
            if (wr.rm_we)
                cur.rm <= wr.val.rm;
        end
    end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_req,
    input  logic [1:0]      csr_sel,
    input  logic            csr_dbg,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] csr_wmask,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_err,
    input  logic [1:0]      fs_in,
    output logic            fs_upd_en,
    output logic [1:0]      fs_upd_val,
    input  logic            acc_valid,
    input  logic [4:0]      acc_flags,
    output logic [2:0]      rm_o,
    output logic [4:0]      flags_o
);
    view_e           sel;
    logic            refused;
    logic            granted;
    logic            wr_go;
    logic [XLEN-1:0] view_rdata;
    fpwr_t           wr;
    fpstate_t        cur;

    assign sel = view_e'(csr_sel);

    fpcsr_gate #(.XLEN(XLEN)) u_gate (
        .req        (csr_req),
        .sel        (sel),
        .dbg        (csr_dbg),
        .fs_in      (fs_in),
        .wmask      (csr_wmask),
        .refused    (refused),
        .granted    (granted),
        .wr_go      (wr_go),
        .fs_upd_en  (fs_upd_en),
        .fs_upd_val (fs_upd_val)
    );

    fpcsr_view #(.XLEN(XLEN)) u_view (
        .sel   (sel),
        .cur   (cur),
        .wdata (csr_wdata),
        .wmask (csr_wmask),
        .wr_go (wr_go),
        .rdata (view_rdata),
        .wr    (wr)
    );

    fpcsr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .acc_valid (acc_valid),
        .acc_flags (acc_flags),
        .cur       (cur)
    );

    assign csr_rdata = granted ? view_rdata : '0;
    assign csr_err   = refused;
    assign rm_o      = cur.rm;
    assign flags_o   = cur.flg;
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_req,
    input logic [1:0]      csr_sel,
    input logic            csr_dbg,
    input logic [XLEN-1:0] csr_wmask,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_err,
    input logic [1:0]      fs_in,
    input logic            fs_upd_en,
    input logic [1:0]      fs_upd_val,
    input logic            acc_valid,
    input logic [4:0]      acc_flags,
    input logic [2:0]      rm_o,
    input logic [4:0]      flags_o
);
    logic blocked;
    assign blocked = csr_req && ((fs_in == 2'b00 && !csr_dbg) || csr_sel == 2'd3);

    assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (csr_err && !fs_upd_en && csr_rdata == '0));

    assert_write_dirty_R9: assert property (@(posedge clk) disable iff (rst)
        (csr_req && !blocked && csr_wmask != '0) |-> (fs_upd_en && fs_upd_val == 2'b11));

    assert_readonly_clean_R13: assert property (@(posedge clk) disable iff (rst)
        (csr_wmask == '0) |-> !fs_upd_en);

    assert_rm_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (csr_req && csr_sel == 2'd1) |-> (csr_rdata[XLEN-1:3] == '0));

    assert_rm_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fs_upd_en)) |-> $stable(rm_o));

    assert_accum_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_valid) && !$past(fs_upd_en))
            |-> ((flags_o & $past(acc_flags)) == $past(acc_flags)));
endmodule

bind fpcsr_unit fpcsr_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .csr_req    (csr_req),
    .csr_sel    (csr_sel),
    .csr_dbg    (csr_dbg),
    .csr_wmask  (csr_wmask),
    .csr_rdata  (csr_rdata),
    .csr_err    (csr_err),
    .fs_in      (fs_in),
    .fs_upd_en  (fs_upd_en),
    .fs_upd_val (fs_upd_val),
    .acc_valid  (acc_valid),
    .acc_flags  (acc_flags),
    .rm_o       (rm_o),
    .flags_o    (flags_o)
);

// File: tb/fpcsr_unit_tb.sv
module fpcsr_unit_tb;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            csr_req;
    logic [1:0]      csr_sel;
    logic            csr_dbg;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_wmask;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_err;
    logic [1:0]      fs_in;
    logic            fs_upd_en;
    logic [1:0]      fs_upd_val;
    logic            acc_valid;
    logic [4:0]      acc_flags;
    logic [2:0]      rm_o;
    logic [4:0]      flags_o;

    always #2.5 clk = ~clk;

    fpcsr_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .csr_req(csr_req), .csr_sel(csr_sel),
        .csr_dbg(csr_dbg), .csr_wdata(csr_wdata), .csr_wmask(csr_wmask),
        .csr_rdata(csr_rdata), .csr_err(csr_err), .fs_in(fs_in),
        .fs_upd_en(fs_upd_en), .fs_upd_val(fs_upd_val),
        .acc_valid(acc_valid), .acc_flags(acc_flags),
        .rm_o(rm_o), .flags_o(flags_o)
    );

    typedef struct {
        logic [XLEN-1:0] rdata;
        logic            err;
        logic [2:0]      fs;
        logic [2:0]      rm;
        logic [4:0]      flg;
        string           tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    logic [4:0] m_flg;
    logic [2:0] m_rm;

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(string tag, logic req, logic [1:0] sel, logic dbg,
                        logic [1:0] fs, logic [XLEN-1:0] wd, logic [XLEN-1:0] wm,
                        logic av, logic [4:0] af);
        item_t it;
        logic [XLEN-1:0] old, mrg;
        logic bad, wr;
        @(negedge clk);
        csr_req = req; csr_sel = sel; csr_dbg = dbg; fs_in = fs;
        csr_wdata = wd; csr_wmask = wm; acc_valid = av; acc_flags = af;
        case (sel)
            2'd0: old = {27'd0, m_flg};
            2'd1: old = {29'd0, m_rm};
            2'd2: old = {24'd0, m_rm, m_flg};
            default: old = '0;
        endcase
        bad = req && ((fs == 2'b00 && !dbg) || sel == 2'd3);
        wr  = req && !bad && (wm != '0);
        it.rdata = (req && !bad) ? old : '0;
        it.err   = bad;
        it.fs    = wr ? 3'b111 : {1'b0, fs};
        it.rm    = m_rm;
        it.flg   = m_flg;
        it.tag   = tag;
        q.push_back(it);
        mrg = (old & ~wm) | (wd & wm);
        if (wr && (sel == 2'd0 || sel == 2'd2)) m_flg = mrg[4:0];
        else if (av) m_flg = m_flg | af;
        if (wr && sel == 2'd1) m_rm = mrg[2:0];
        if (wr && sel == 2'd2) m_rm = mrg[7:5];
    endtask

    // monitor: compare after the driver's negedge, away from posedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                chk(e.tag, "rdata", csr_rdata, e.rdata);
                chk(e.tag, "err", {31'd0, csr_err}, {31'd0, e.err});
                chk(e.tag, "fs_upd", {29'd0, fs_upd_en, fs_upd_val}, {29'd0, e.fs});
                chk(e.tag, "rm_o", {29'd0, rm_o}, {29'd0, e.rm});
                chk(e.tag, "flags_o", {27'd0, flags_o}, {27'd0, e.flg});
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [XLEN-1:0] ALL = '1;

    initial begin
        m_flg = '0; m_rm = '0;
        rst = 1'b1; csr_req = 0; csr_sel = 0; csr_dbg = 0; fs_in = 2'b01;
        csr_wdata = '0; csr_wmask = '0; acc_valid = 0; acc_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step("R1 reset packed", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        step("R1 reset rm", 1, 1, 0, 2'b01, 0, 0, 0, 0);
        step("R2 R9 flags write", 1, 0, 0, 2'b01, ALL, ALL, 0, 0);
        step("R2 flags read", 1, 0, 0, 2'b10, 0, 0, 0, 0);
        step("R3 rm write", 1, 1, 0, 2'b01, 32'hFFFF_FFFD, ALL, 0, 0);
        step("R4 packed read", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        step("R5 rmw clear", 1, 2, 0, 2'b01, 0, 32'h3, 0, 0);
        step("R5 rmw set", 1, 2, 0, 2'b01, 32'h0000_0041, 32'h0000_0041, 0, 0);
        step("R6 upper ignored", 1, 2, 0, 2'b01, 32'hFFFF_FF4A, ALL, 0, 0);
        step("R6 packed read", 1, 2, 0, 2'b11, 0, 0, 0, 0);
        step("R7 refused write", 1, 0, 0, 2'b00, ALL, ALL, 0, 0);
        step("R7 refused read", 1, 2, 0, 2'b00, 0, 0, 0, 0);
        step("R7 state kept", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        step("R8 debug write", 1, 1, 1, 2'b00, 32'h7, ALL, 0, 0);
        step("R8 debug read", 1, 2, 1, 2'b00, 0, 0, 0, 0);
        step("R13 read only", 1, 0, 0, 2'b10, ALL, 0, 0, 0);
        step("R10 accumulate", 0, 0, 0, 2'b01, 0, 0, 1, 5'h11);
        step("R10 accumulate more", 0, 0, 0, 2'b01, 0, 0, 1, 5'h04);
        step("R10 flags read", 1, 0, 0, 2'b01, 0, 0, 0, 0);
        step("R11 flags write wins", 1, 0, 0, 2'b01, 32'h2, ALL, 1, 5'h10);
        step("R11 packed write wins", 1, 2, 0, 2'b01, 32'h21, ALL, 1, 5'h08);
        step("R11 rm write plus acc", 1, 1, 0, 2'b01, 32'h3, ALL, 1, 5'h10);
        step("R11 packed read", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        step("R12 bad view", 1, 3, 0, 2'b01, ALL, ALL, 0, 0);
        step("R12 bad view debug", 1, 3, 1, 2'b01, ALL, ALL, 0, 0);
        step("R12 state kept", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        step("R9 flags rmw dirty", 1, 0, 0, 2'b01, 32'h1, 32'h1, 0, 0);
        step("R1 reset again", 0, 0, 0, 2'b01, 0, 0, 0, 0);

        @(negedge clk);
        csr_req = 0; acc_valid = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_flg = '0; m_rm = '0;
        step("R1 after reset", 1, 2, 0, 2'b01, 0, 0, 0, 0);
        @(negedge clk);
        csr_req = 0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule